// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register accesses on an external PHY over the two-wire MII management bus. A host pulses a start strobe together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then builds the serial frame, drives the management clock and data lines, and pulses a done strobe when the access is over. For reads it also presents the 16-bit result.

The management clock is derived from the system clock. Its half period is the smallest whole number of system cycles that keeps the clock at or below a configured maximum, 2.5 MHz by default. Each access can open with a synchronisation run of ones, selected per access. A read sends a 16-bit header and then releases the data line for a fixed 20-clock capture window. The result is taken from the middle of that window. A write sends a 32-bit frame and then releases the line for two more clocks.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy_o, done_o, mdc_o, mdio_oe_o and rd_data_o are all 0.
- R2: With preamble_en_i high at the accepted start, the first 32 rising mdc_o edges see mdio_o = 1 with mdio_oe_o = 1.
- R3: A read drives 16 bits, MSB first, with mdio_oe_o = 1: 1,1,0,1,1,0, then phy_addr_i[4:0], then reg_addr_i[4:0].
- R4: After the read header, mdio_oe_o is 0 for exactly 20 clocks. mdio_i is sampled at each of these rising edges into a 20-bit value, first sample in bit 19. rd_data_o becomes bits 16:1 of that value.
- R5: A write drives 32 bits, MSB first, with mdio_oe_o = 1: 0,1,0,1, phy_addr_i[4:0], reg_addr_i[4:0], 1,0, then wr_data_i[15:0].
- R6: After the write frame, exactly two more clocks run with mdio_oe_o = 0, and then the access ends.
- R7: mdc_o stays high for HALF and low for HALF system cycles between edges, where HALF = ceil(CLK_HZ / (2*MDC_MAX_HZ)), which is 40 at the defaults. mdc_o is low while idle.
- R8: mdio_o and mdio_oe_o change only on the system edge where mdc_o falls, never while mdc_o stays high.
- R9: A start pulse while busy_o is high is ignored; the running frame goes on unchanged and no second access follows.
- R10: done_o is a one-cycle pulse. It is asserted in the cycle where busy_o has just returned to 0. busy_o is high from the cycle after the accepted start.
- R11: rd_data_o changes only at the end of a read and holds its value through later writes.
- R12: With preamble_en_i low, the frame starts directly with the header, so the access takes 32 fewer clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| preamble_en_i | input | 1 | Send 32 ones before the header |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Result of the last read |
| done_o | output | 1 | One-cycle end-of-access pulse |
| busy_o | output | 1 | Access in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume the command fields are held valid only in the start cycle, because they are captured there. They also assume mdio_i is settled before each rising management clock edge; the block makes no claim about the value on a released line. The stimulus drives all inputs on the falling system clock edge. The bench's PHY model moves the returned bit only on a rising mdc_o edge, so each sampled bit has been stable for a full management clock period. Start pulses are issued idle and mid-frame, and the read capture patterns are chosen so that a window shifted by one bit yields a different result.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DRIVE, ST_RELEASE} mdio_st_e;

  localparam int HDR_RD_BITS = 16;
  localparam int FRAME_WR_BITS = 32;

  // start 01 preceded by two ones, opcode 10
  function automatic logic [15:0] rd_header(logic [4:0] phy, logic [4:0] regad);
    return {6'b110110, phy, regad};
  endfunction

  // start 01, opcode 01, turnaround 10
  function automatic logic [31:0] wr_frame(logic [4:0] phy, logic [4:0] regad,
                                           logic [15:0] data);
    return {4'b0101, phy, regad, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int HALF_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

  logic [DIV_W-1:0] div_q;
  logic wrap;

  assign wrap   = (div_q == DIV_LAST);
  assign rise_o = run_i & wrap & ~mdc_o;
  assign fall_o = run_i & wrap & mdc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      mdc_o <= 1'b0;
    end else if (!run_i) begin
      div_q <= '0;
      mdc_o <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assert_mdc_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng import mdio_pkg::*; #(
  parameter int PRE_BITS = 32,
  parameter int RD_WIN   = 20,
  parameter int WR_TAIL  = 2,
  parameter int DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic              pre_en_i,
  input  logic [4:0]        phy_addr_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              run_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int SH_W  = PRE_BITS + FRAME_WR_BITS;
  localparam int CNT_W = $clog2(SH_W + 1);

  mdio_st_e           st_q;
  logic [SH_W-1:0]    sh_q;
  logic [CNT_W-1:0]   left_q;
  logic [RD_WIN-1:0]  cap_q;
  logic               is_rd_q;
  logic               accept;
  logic [31:0]        frame;
  logic [SH_W-1:0]    load;
  logic [CNT_W-1:0]   n_drive;

  assign accept = start_i && (st_q == ST_IDLE);
  assign frame  = rd_i ? {rd_header(phy_addr_i, reg_addr_i), 16'h0000}
                       : wr_frame(phy_addr_i, reg_addr_i, wr_data_i);
  assign load   = pre_en_i ? {{PRE_BITS{1'b1}}, frame} : {frame, {PRE_BITS{1'b0}}};
  assign n_drive = CNT_W'((pre_en_i ? PRE_BITS : 0) + (rd_i ? HDR_RD_BITS : FRAME_WR_BITS));

  assign mdio_o = sh_q[SH_W-1];
  assign busy_o = (st_q != ST_IDLE);
  assign run_o  = busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sh_q      <= '1;
      left_q    <= '0;
      cap_q     <= '0;
      is_rd_q   <= 1'b0;
      mdio_oe_o <= 1'b0;
      rd_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          is_rd_q   <= rd_i;
          sh_q      <= load;
          left_q    <= n_drive;
          mdio_oe_o <= 1'b1;
          st_q      <= ST_DRIVE;
        end
        ST_DRIVE: if (fall_i) begin
          if (left_q == CNT_W'(1)) begin
            st_q      <= ST_RELEASE;
            mdio_oe_o <= 1'b0;
            sh_q      <= '1;
            left_q    <= is_rd_q ? CNT_W'(RD_WIN) : CNT_W'(WR_TAIL);
          end else begin
            sh_q   <= {sh_q[SH_W-2:0], 1'b1};
            left_q <= left_q - 1'b1;
          end
        end
        ST_RELEASE: begin
          if (rise_i) cap_q <= {cap_q[RD_WIN-2:0], mdio_i};
          if (fall_i) begin
            if (left_q == CNT_W'(1)) begin
              st_q   <= ST_IDLE;
              done_o <= 1'b1;
              if (is_rd_q) rd_data_o <= cap_q[DATA_W:1];
            end else begin
              left_q <= left_q - 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_oe_off_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o);
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(is_rd_q));
  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_at_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rd_data_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CLK_HZ     = 200_000_000,
  parameter int MDC_MAX_HZ = 2_500_000,
  parameter int PRE_BITS   = 32,
  parameter int RD_WIN     = 20,
  parameter int WR_TAIL    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic        preamble_en_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  output logic        done_o,
  output logic        busy_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int HALF_RAW = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
  localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic run, rise, fall;

  mdio_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng #(
    .PRE_BITS (PRE_BITS),
    .RD_WIN   (RD_WIN),
    .WR_TAIL  (WR_TAIL),
    .DATA_W   (16)
  ) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rd_i       (rd_i),
    .pre_en_i   (preamble_en_i),
    .phy_addr_i (phy_addr_i),
    .reg_addr_i (reg_addr_i),
    .wr_data_i  (wr_data_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdio_i     (mdio_i),
    .run_o      (run),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .rd_data_o  (rd_data_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  assert_data_quiet_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, rd = 1'b0, pre = 1'b0;
  logic [4:0] phy = '0, rga = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic done, busy, mdc, mdo, moe, mdi;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mdio_master dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .rd_i(rd),
    .preamble_en_i(pre), .phy_addr_i(phy), .reg_addr_i(rga), .wr_data_i(wd),
    .rd_data_o(rdata), .done_o(done), .busy_o(busy), .mdc_o(mdc),
    .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi)
  );

  // edge recorder and PHY model
  logic [15:0] r = '0;
  logic [15:0] base = '0;
  logic [6:0]  idx;
  logic        seen_d [0:127];
  logic        seen_oe[0:127];
  logic        rd_cur = 1'b0;
  logic [6:0]  hdr_n = '0;
  logic [19:0] pat = '0;
  logic [7:0]  kk;
  logic        in_win;

  assign idx    = 7'(r - base);
  assign kk     = 8'(idx) - 8'(hdr_n);
  assign in_win = rd_cur && (idx >= hdr_n) && (kk < 8'd20);
  assign mdi    = in_win ? pat[5'd19 - kk[4:0]] : 1'b1;

  always @(posedge mdc) begin
    seen_d[idx]  <= mdo;
    seen_oe[idx] <= moe;
    r <= r + 16'd1;
  end

  // R8 / R7 monitors
  logic p_mdc = 1'b0, p_d = 1'b0, p_oe = 1'b0;
  int viol = 0;
  int hi_len = 0, lo_len = 0, hi_min = 9999, hi_max = 0, lo_min = 9999, lo_max = 0;
  logic after_fall = 1'b0;
  always @(negedge clk) begin
    if (mdc && p_mdc && (mdo !== p_d || moe !== p_oe)) viol++;
    if (mdc) begin
      hi_len++;
      if (!p_mdc && after_fall) begin
        if (lo_len < lo_min) lo_min = lo_len;
        if (lo_len > lo_max) lo_max = lo_len;
      end
      lo_len = 0;
    end else begin
      if (p_mdc) begin
        if (hi_len < hi_min) hi_min = hi_len;
        if (hi_len > hi_max) hi_max = hi_len;
        after_fall = 1'b1;
      end
      hi_len = 0;
      lo_len++;
      if (!busy) after_fall = 1'b0;
    end
    p_mdc = mdc; p_d = mdo; p_oe = moe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input bit r_i, input bit p_i, input logic [4:0] ph,
                       input logic [4:0] rg, input logic [15:0] d);
    @(negedge clk);
    base = r;
    rd_cur = r_i;
    hdr_n = p_i ? 7'd48 : 7'd16;
    rd = r_i; pre = p_i; phy = ph; rga = rg; wd = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rd = 1'b0; phy = '0; rga = '0; wd = '0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done === 1'b1, req, n, 0);
    chk(busy === 1'b0, "R10 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done single pulse", int'(done), 0);
  endtask

  task automatic t_reset;
    chk(busy === 0 && done === 0 && mdc === 0 && moe === 0 && rdata === 0,
        "R1 reset state", int'({busy, done, mdc, moe}), 0);
  endtask

  task automatic t_read(input bit p_i, input logic [4:0] ph, input logic [4:0] rg,
                        input logic [19:0] pt);
    logic [15:0] hdr;
    int bad, off;
    pat = pt;
    hdr = {6'b110110, ph, rg};
    issue(1'b1, p_i, ph, rg, 16'h0);
    chk(busy === 1'b1, "R10 busy after start", int'(busy), 1);
    wait_done("R4 read completes");
    off = p_i ? 32 : 0;
    chk(int'(16'(r - base)) == off + 36, p_i ? "R2 read clock count" : "R12 read clock count",
        int'(16'(r - base)), off + 36);
    bad = 0;
    for (int i = 0; i < off; i++) if (seen_d[i] !== 1'b1 || seen_oe[i] !== 1'b1) bad++;
    if (p_i) chk(bad == 0, "R2 preamble ones", bad, 0);
    bad = 0;
    for (int i = 0; i < 16; i++)
      if (seen_d[off+i] !== hdr[15-i] || seen_oe[off+i] !== 1'b1) bad++;
    chk(bad == 0, "R3 read header", bad, 0);
    bad = 0;
    for (int i = 0; i < 20; i++) if (seen_oe[off+16+i] !== 1'b0) bad++;
    chk(bad == 0, "R4 released window", bad, 0);
    chk(rdata === pt[16:1], "R4 read data", int'(rdata), int'(pt[16:1]));
  endtask

  task automatic t_write(input bit p_i, input logic [4:0] ph, input logic [4:0] rg,
                         input logic [15:0] d);
    logic [31:0] fr;
    logic [15:0] keep;
    int bad, off;
    keep = rdata;
    fr = {4'b0101, ph, rg, 2'b10, d};
    issue(1'b0, p_i, ph, rg, d);
    wait_done("R5 write completes");
    off = p_i ? 32 : 0;
    chk(int'(16'(r - base)) == off + 34, "R6 write clock count", int'(16'(r - base)), off + 34);
    bad = 0;
    for (int i = 0; i < off; i++) if (seen_d[i] !== 1'b1 || seen_oe[i] !== 1'b1) bad++;
    if (p_i) chk(bad == 0, "R2 write preamble", bad, 0);
    bad = 0;
    for (int i = 0; i < 32; i++)
      if (seen_d[off+i] !== fr[31-i] || seen_oe[off+i] !== 1'b1) bad++;
    chk(bad == 0, "R5 write frame", bad, 0);
    chk(seen_oe[off+32] === 1'b0 && seen_oe[off+33] === 1'b0, "R6 released tail",
        int'({seen_oe[off+32], seen_oe[off+33]}), 0);
    chk(rdata === keep, "R11 read data held over write", int'(rdata), int'(keep));
  endtask

  task automatic t_busy_ignore;
    logic [31:0] fr;
    logic [15:0] keep;
    int bad;
    keep = rdata;
    fr = {4'b0101, 5'd3, 5'd9, 2'b10, 16'h1234};
    issue(1'b0, 1'b1, 5'd3, 5'd9, 16'h1234);
    repeat (300) @(negedge clk);
    rd = 1'b1; phy = 5'd31; rga = 5'd31; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rd = 1'b0;
    wait_done("R9 frame finishes");
    chk(int'(16'(r - base)) == 66, "R9 no extra clocks", int'(16'(r - base)), 66);
    bad = 0;
    for (int i = 0; i < 32; i++) if (seen_d[32+i] !== fr[31-i]) bad++;
    chk(bad == 0, "R9 frame unchanged", bad, 0);
    repeat (200) @(negedge clk);
    chk(busy === 1'b0 && mdc === 1'b0, "R9 no second access", int'(busy), 0);
    chk(rdata === keep, "R11 held after ignored read", int'(rdata), int'(keep));
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(1'b1, 5'd1, 5'd2, {2'b10, 16'hBEEF, 2'b11});
    t_read(1'b0, 5'd17, 5'd5, 20'hA5C3F);
    t_write(1'b1, 5'd6, 5'd4, 16'h01E1);
    t_write(1'b0, 5'd31, 5'd0, 16'h8001);
    t_read(1'b1, 5'd0, 5'd31, 20'h5A3C6);
    t_busy_ignore();
    chk(viol == 0, "R8 data quiet while clock high", viol, 0);
    chk(hi_min == 40 && hi_max == 40, "R7 high width", hi_max, 40);
    chk(lo_min == 40 && lo_max == 40, "R7 low width", lo_max, 40);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule